// File: doc/BRIEF.md
# LPC Host I/O Cycle Controller

This block is a register-programmed host for the Low Pin Count bus. Software loads a command word, a byte count, a 16-bit I/O address and, for writes, the outgoing bytes. It then sets a start bit. The controller runs one bus cycle per byte on the 4-bit LAD lines with the active-low frame strobe. In order, each cycle has a start nibble, a cycle-type nibble, the address, any write data, a host turnaround, a sync phase from the peripheral, any read data, and a peripheral turnaround. Returned bytes are queued for software to pop one register read at a time.

When the operation ends, the controller sets a sticky interrupt flag and records a pass or fail result. A peripheral can stretch the sync phase with wait codes, up to a programmable limit. If the limit is exceeded, the controller aborts the bus. Only I/O cycles are carried out; a command for any other cycle type, or a zero length, is refused at once with a failed status.

Top module: `lpc_host_ctrl`

## Requirements
- R1: After reset, status reads idle (bit 0 = 1) with pass clear (bit 1 = 0), the interrupt output is low, the frame strobe is high and LAD is not driven.
- R2: Command word at offset 0x14: bit 0 = 1 write / 0 read, bits [2:1] cycle type (00 I/O, 01 memory, 10 firmware hub), bit 3 = 1 same address / 0 incrementing. Writing 1 to bit 0 of offset 0x00 while idle starts the operation. A non-I/O type finishes at once with fail, an interrupt, and no bus activity.
- R3: Each byte's cycle drives the frame strobe low for exactly one clock with LAD = 0000. It then drives LAD 0000 (I/O read) or 0010 (I/O write), then four address nibbles, most significant first.
- R4: A write then drives two data nibbles taken from the write queue (filled through offset 0x24), low nibble first. Every cycle then has a host turnaround: LAD = 1111 driven for one clock, then released for one clock.
- R5: In sync the peripheral's LAD value 0000 means ready. 1010 means error. Any other value (0101 and 0110 in use) is a wait that extends the phase.
- R6: For a read, after ready sync two nibbles are captured, low first, and queued. Each read of offset 0x28 returns the oldest byte in bits [7:0] and removes it.
- R7: After the data (or the sync, for writes) the bus is left undriven for a two-clock peripheral turnaround, before the next byte or idle.
- R8: With bit 3 clear, byte n of a multi-byte operation uses the start address plus n. With bit 3 set, every byte uses the start address. Completion is signalled only after the last byte.
- R9: Bit 1 of offset 0x08 (mirrored on irq_o) sets when an operation ends and stays set until software writes 1 to that bit.
- R10: Offset 0x04 reports idle in bit 0, the last result's pass in bit 1, and the phase code in bits [11:8]: idle 0, start 1, type 2, address 3, size 4, write data 5, host turnaround 6, sync 7, read data 8, peripheral turnaround 9, abort 10.
- R11: An error sync ends the operation after the peripheral turnaround with fail. Remaining bytes are skipped.
- R12: With timeout T at offset 0x58, up to T wait clocks are accepted. On the next wait the controller aborts: the frame strobe is low with LAD = 1111 driven for four clocks, then it returns to idle with fail.
- R13: A start with a byte count of 0 (offset 0x10) finishes at once with fail and an interrupt, with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, shared by register port and bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops read queue at 0x28) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| lframe_no | output | 1 | Frame strobe, active low |
| lad_o | output | 4 | LAD value driven by host |
| lad_oe_o | output | 1 | LAD output enable |
| lad_i | input | 4 | LAD value seen on the bus |
| irq_o | output | 1 | Level interrupt, operation ended |

## Verification
The bench builds the controller with a 4-deep byte queue, a 4-bit length field and an 8-bit timeout, so that full-queue multi-byte operations and timeout windows stay only a few clocks long. Short timeouts bring the abort reach, and the exact-limit case that must still pass, within a handful of sync clocks. Random I/O reads and writes with random addresses, lengths and wait counts are mixed with directed error-sync, abort, refused-type and zero-length runs. A bench-side peripheral checks every bus nibble as it happens.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;
  typedef enum logic [3:0] {
    PH_IDLE  = 4'd0,
    PH_START = 4'd1,
    PH_CTD   = 4'd2,
    PH_ADDR  = 4'd3,
    PH_MSIZE = 4'd4,
    PH_WDATA = 4'd5,
    PH_TAR_H = 4'd6,
    PH_SYNC  = 4'd7,
    PH_RDATA = 4'd8,
    PH_TAR_P = 4'd9,
    PH_ABORT = 4'd10
  } phase_e;

  localparam int unsigned IO_ADDR_W = 16;
  localparam logic [1:0]  CT_IO     = 2'b00;
  localparam logic [3:0]  NIB_START = 4'h0;
  localparam logic [3:0]  NIB_IDLE  = 4'hF;
  localparam logic [3:0]  SYNC_RDY  = 4'h0;
  localparam logic [3:0]  SYNC_ERR  = 4'hA;

  localparam logic [7:0] OFF_START = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_IRQ   = 8'h08;
  localparam logic [7:0] OFF_LEN   = 8'h10;
  localparam logic [7:0] OFF_CMD   = 8'h14;
  localparam logic [7:0] OFF_ADDR  = 8'h20;
  localparam logic [7:0] OFF_WDAT  = 8'h24;
  localparam logic [7:0] OFF_RDAT  = 8'h28;
  localparam logic [7:0] OFF_TMO   = 8'h58;
endpackage

// File: rtl/lpc_byte_fifo.sv
module lpc_byte_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R6
  AST_FIFO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
endmodule

// File: rtl/lpc_bus_seq.sv
module lpc_bus_seq
  import lpc_host_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned TMO_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 wr_i,
  input  logic [1:0]           ctype_i,
  input  logic                 same_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [IO_ADDR_W-1:0] addr_i,
  input  logic [TMO_W-1:0]     tmo_i,
  input  logic [7:0]           tx_data_i,
  output logic                 tx_pop_o,
  output logic [7:0]           rx_data_o,
  output logic                 rx_push_o,
  output logic                 lframe_no,
  output logic [3:0]           lad_o,
  output logic                 lad_oe_o,
  input  logic [3:0]           lad_i,
  output phase_e               phase_o,
  output logic                 done_o,
  output logic                 ok_o
);
  localparam int unsigned NIBS = IO_ADDR_W / 4;

  phase_e               phase_q;
  logic [1:0]           sub_q;
  logic [IO_ADDR_W-1:0] addr_q, addr_sh;
  logic [LEN_W-1:0]     left_q;
  logic [TMO_W-1:0]     wait_q;
  logic [3:0]           lo_q;
  logic                 wr_q, same_q, err_q, bad, last_byte;

  assign bad       = (ctype_i != CT_IO) || (len_i == '0);
  assign last_byte = (left_q == LEN_W'(1)) || err_q;
  assign addr_sh   = addr_q >> (4 * (NIBS - 1 - int'(sub_q)));
  assign phase_o   = phase_q;

  always_comb begin
    lframe_no = 1'b1;
    lad_oe_o  = 1'b0;
    lad_o     = NIB_IDLE;
    unique case (phase_q)
      PH_START: begin lframe_no = 1'b0; lad_oe_o = 1'b1; lad_o = NIB_START; end
      PH_CTD:   begin lad_oe_o = 1'b1; lad_o = {2'b00, wr_q, 1'b0}; end
      PH_ADDR:  begin lad_oe_o = 1'b1; lad_o = addr_sh[3:0]; end
      PH_WDATA: begin lad_oe_o = 1'b1; lad_o = sub_q[0] ? tx_data_i[7:4] : tx_data_i[3:0]; end
      PH_TAR_H: lad_oe_o = (sub_q == 2'd0);
      PH_ABORT: begin lframe_no = 1'b0; lad_oe_o = 1'b1; end
      default:  ;
    endcase
  end

  assign tx_pop_o  = (phase_q == PH_WDATA) && sub_q[0];
  assign rx_push_o = (phase_q == PH_RDATA) && sub_q[0];
  assign rx_data_o = {lad_i, lo_q};
  assign ok_o      = (phase_q == PH_TAR_P) && !err_q;
  assign done_o    = ((phase_q == PH_IDLE) && start_i && bad)
                   || ((phase_q == PH_TAR_P) && sub_q[0] && last_byte)
                   || ((phase_q == PH_ABORT) && (sub_q == 2'd3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      sub_q   <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      wait_q  <= '0;
      lo_q    <= '0;
      wr_q    <= 1'b0;
      same_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i && !bad) begin
          phase_q <= PH_START;
          addr_q  <= addr_i;
          left_q  <= len_i;
          wr_q    <= wr_i;
          same_q  <= same_i;
          err_q   <= 1'b0;
        end
        PH_START: phase_q <= PH_CTD;
        PH_CTD: begin phase_q <= PH_ADDR; sub_q <= '0; end
        PH_ADDR: if (sub_q == 2'(NIBS - 1)) begin
          phase_q <= wr_q ? PH_WDATA : PH_TAR_H;
          sub_q   <= '0;
        end else sub_q <= sub_q + 1'b1;
        PH_WDATA: if (sub_q[0]) begin phase_q <= PH_TAR_H; sub_q <= '0; end
                  else sub_q <= 2'd1;
        PH_TAR_H: if (sub_q[0]) begin phase_q <= PH_SYNC; sub_q <= '0; wait_q <= '0; end
                  else sub_q <= 2'd1;
        PH_SYNC: begin
          if (lad_i == SYNC_RDY) phase_q <= wr_q ? PH_TAR_P : PH_RDATA;
          else if (lad_i == SYNC_ERR) begin err_q <= 1'b1; phase_q <= PH_TAR_P; end
          else if (wait_q == tmo_i) phase_q <= PH_ABORT;
          else wait_q <= wait_q + 1'b1;
          sub_q <= '0;
        end
        PH_RDATA: if (sub_q[0]) begin phase_q <= PH_TAR_P; sub_q <= '0; end
                  else begin lo_q <= lad_i; sub_q <= 2'd1; end
        PH_TAR_P: if (!sub_q[0]) sub_q <= 2'd1;
          else begin
            sub_q <= '0;
            if (last_byte) phase_q <= PH_IDLE;
            else begin
              phase_q <= PH_START;
              left_q  <= left_q - 1'b1;
              addr_q  <= addr_q + {{(IO_ADDR_W-1){1'b0}}, ~same_q};
            end
          end
        PH_ABORT: if (sub_q == 2'd3) begin phase_q <= PH_IDLE; sub_q <= '0; end
                  else sub_q <= sub_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_START_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_START) |=> (phase_q == PH_CTD && lframe_no)); // R3
  AST_SYNC_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SYNC) |-> !$past(lad_oe_o)); // R4
  AST_ABORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_ABORT) |-> !lframe_no ##1 !lframe_no ##1 !lframe_no ##1 !lframe_no); // R12
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (phase_q == PH_IDLE)); // R8
  AST_TAR_P_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TAR_P) |=> !lad_oe_o || (phase_q == PH_START)); // R7
endmodule

// File: rtl/lpc_host_ctrl.sv
module lpc_host_ctrl
  import lpc_host_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned TMO_W      = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        lframe_no,
  output logic [3:0]  lad_o,
  output logic        lad_oe_o,
  input  logic [3:0]  lad_i,
  output logic        irq_o
);
  logic [3:0]           cmd_q;
  logic [LEN_W-1:0]     len_q;
  logic [IO_ADDR_W-1:0] addr_q;
  logic [TMO_W-1:0]     tmo_q;
  logic                 irq_q, ok_q;
  phase_e               phase;
  logic                 idle, start, irq_clr, done, ok;
  logic                 tx_pop, tx_empty, rx_push, rx_empty, rx_pop;
  logic [7:0]           tx_data, rx_data, rx_head;

  assign idle    = (phase == PH_IDLE);
  assign start   = reg_we_i && (reg_addr_i == OFF_START) && reg_wdata_i[0] && idle;
  assign irq_clr = reg_we_i && (reg_addr_i == OFF_IRQ) && reg_wdata_i[1];
  assign rx_pop  = reg_re_i && (reg_addr_i == OFF_RDAT);
  assign irq_o   = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      len_q  <= '0;
      addr_q <= '0;
      tmo_q  <= '1;
      irq_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      if (reg_we_i) begin
        unique case (reg_addr_i)
          OFF_CMD:  cmd_q  <= reg_wdata_i[3:0];
          OFF_LEN:  len_q  <= reg_wdata_i[LEN_W-1:0];
          OFF_ADDR: addr_q <= reg_wdata_i[IO_ADDR_W-1:0];
          OFF_TMO:  tmo_q  <= reg_wdata_i[TMO_W-1:0];
          default:  ;
        endcase
      end
      if (done)         irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (done)       ok_q <= ok;
      else if (start) ok_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFF_STAT: reg_rdata_o = {20'd0, phase, 6'd0, ok_q, idle};
      OFF_IRQ:  reg_rdata_o = {30'd0, irq_q, 1'b0};
      OFF_LEN:  reg_rdata_o = 32'(len_q);
      OFF_CMD:  reg_rdata_o = {28'd0, cmd_q};
      OFF_ADDR: reg_rdata_o = 32'(addr_q);
      OFF_RDAT: reg_rdata_o = rx_empty ? 32'd0 : {24'd0, rx_head};
      OFF_TMO:  reg_rdata_o = 32'(tmo_q);
      default:  reg_rdata_o = 32'd0;
    endcase
  end

  lpc_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (reg_we_i && (reg_addr_i == OFF_WDAT)),
    .wdata_i(reg_wdata_i[7:0]),
    .pop_i  (tx_pop),
    .rdata_o(tx_data),
    .empty_o(tx_empty)
  );

  lpc_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .wdata_i(rx_data),
    .pop_i  (rx_pop),
    .rdata_o(rx_head),
    .empty_o(rx_empty)
  );

  lpc_bus_seq #(.LEN_W(LEN_W), .TMO_W(TMO_W)) i_seq (
    .clk_i, .rst_ni,
    .start_i  (start),
    .wr_i     (cmd_q[0]),
    .ctype_i  (cmd_q[2:1]),
    .same_i   (cmd_q[3]),
    .len_i    (len_q),
    .addr_i   (addr_q),
    .tmo_i    (tmo_q),
    .tx_data_i(tx_data),
    .tx_pop_o (tx_pop),
    .rx_data_o(rx_data),
    .rx_push_o(rx_push),
    .lframe_no,
    .lad_o,
    .lad_oe_o,
    .lad_i,
    .phase_o  (phase),
    .done_o   (done),
    .ok_o     (ok)
  );

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr) |=> irq_q); // R9
  AST_REFUSE_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && (cmd_q[2:1] != CT_IO)) |=> (lframe_no && irq_q && !ok_q)); // R2
  AST_ZERO_LEN_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && (len_q == '0)) |=> (lframe_no && irq_q)); // R13
  AST_TX_NOT_STARVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |-> !tx_empty || !lad_oe_o || lframe_no); // R4
endmodule

// File: tb/test_lpc_host_ctrl.sv
`timescale 1ns/1ps
module test_lpc_host_ctrl;
  localparam logic [7:0] A_START = 8'h00, A_STAT = 8'h04, A_IRQ = 8'h08, A_LEN = 8'h10,
                         A_CMD = 8'h14, A_ADDR = 8'h20, A_WDAT = 8'h24, A_RDAT = 8'h28,
                         A_TMO = 8'h58;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [7:0] raddr = '0;
  logic [31:0] wdata = '0, rdata;
  logic lframe_n, lad_oe, irq;
  logic [3:0] lad_out, lad_in = 4'hF;
  int n_chk = 0, n_bad = 0;
  logic [7:0] dat [4];

  always #10 clk = ~clk;

  lpc_host_ctrl #(.FIFO_DEPTH(4), .LEN_W(4), .TMO_W(8)) i_lpc_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lframe_no(lframe_n), .lad_o(lad_out),
    .lad_oe_o(lad_oe), .lad_i(lad_in), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; raddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    re = 1'b1; raddr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  function automatic logic [31:0] bus_word(input logic lf, input logic oe, input logic [3:0] l);
    return {26'd0, lf, oe, oe ? l : 4'h0};
  endfunction

  task automatic bus_cyc(input logic lf, input logic oe, input logic [3:0] l,
                         input logic [3:0] drv, input string tag);
    chk(tag, bus_word(lframe_n, lad_oe, lad_out), bus_word(lf, oe, l));
    lad_in = drv;
    @(negedge clk);
    lad_in = 4'hF;
  endtask

  task automatic run_io(input bit wr, input bit same, input int len, input logic [15:0] addr,
                        input int waits, input int err_b, input int tmo);
    int done_rd = 0;
    bit fail = 0;
    logic [15:0] a;
    logic [7:0] rb [4];
    logic [31:0] d;
    reg_wr(A_CMD, {28'd0, same, 2'b00, wr});
    reg_wr(A_LEN, 32'(len));
    if (wr) for (int i = 0; i < len; i++) reg_wr(A_WDAT, {24'd0, dat[i]});
    reg_wr(A_ADDR, {16'd0, addr});
    reg_wr(A_TMO, 32'(tmo));
    reg_wr(A_START, 32'd1);
    for (int b = 0; b < len && !fail; b++) begin
      a = same ? addr : addr + 16'(b);
      bus_cyc(1'b0, 1'b1, 4'h0, 4'hF, "R3 start");
      bus_cyc(1'b1, 1'b1, {2'b00, wr, 1'b0}, 4'hF, "R3 type");
      for (int n = 3; n >= 0; n--) bus_cyc(1'b1, 1'b1, a[4*n +: 4], 4'hF, "R3 R8 addr");
      if (wr) begin
        bus_cyc(1'b1, 1'b1, dat[b][3:0], 4'hF, "R4 wdata lo");
        bus_cyc(1'b1, 1'b1, dat[b][7:4], 4'hF, "R4 wdata hi");
      end
      bus_cyc(1'b1, 1'b1, 4'hF, 4'hF, "R4 tar drive");
      bus_cyc(1'b1, 1'b0, 4'h0, 4'hF, "R4 tar release");
      if (waits > tmo) begin
        for (int w = 0; w <= tmo; w++) bus_cyc(1'b1, 1'b0, 4'h0, (w % 2) ? 4'h6 : 4'h5, "R5 wait");
        for (int k = 0; k < 4; k++) bus_cyc(1'b0, 1'b1, 4'hF, 4'hF, "R12 abort");
        fail = 1;
      end else begin
        for (int w = 0; w < waits; w++) bus_cyc(1'b1, 1'b0, 4'h0, (w % 2) ? 4'h6 : 4'h5, "R5 wait");
        if (b == err_b) begin
          bus_cyc(1'b1, 1'b0, 4'h0, 4'hA, "R11 error sync");
          fail = 1;
        end else begin
          bus_cyc(1'b1, 1'b0, 4'h0, 4'h0, "R5 ready sync");
          if (!wr) begin
            rb[b] = 8'($urandom);
            bus_cyc(1'b1, 1'b0, 4'h0, rb[b][3:0], "R6 rdata lo");
            bus_cyc(1'b1, 1'b0, 4'h0, rb[b][7:4], "R6 rdata hi");
            done_rd++;
          end
        end
        bus_cyc(1'b1, 1'b0, 4'h0, 4'hF, "R7 tar 1");
        bus_cyc(1'b1, 1'b0, 4'h0, 4'hF, "R7 tar 2");
      end
      if (!fail && b < len - 1) chk("R8 no early irq", {31'd0, irq}, 32'd0);
    end
    chk("R9 irq on end", {31'd0, irq}, 32'd1);
    chk("R3 frame idle after end", {31'd0, lframe_n}, 32'd1);
    reg_rd(A_STAT, d);
    chk(fail ? "R11 R12 fail status" : "R10 pass status", d, fail ? 32'd1 : 32'd3);
    for (int i = 0; i < done_rd; i++) begin
      reg_rd(A_RDAT, d);
      chk("R6 read byte", d, {24'd0, rb[i]});
    end
    reg_wr(A_IRQ, 32'd2);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic refused(input logic [3:0] cmd, input int len, input string tag);
    logic [31:0] d;
    reg_wr(A_CMD, {28'd0, cmd});
    reg_wr(A_LEN, 32'(len));
    reg_wr(A_START, 32'd1);
    chk({tag, " irq"}, {31'd0, irq}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      chk({tag, " no frame"}, bus_word(lframe_n, lad_oe, lad_out), bus_word(1'b1, 1'b0, 4'h0));
      @(negedge clk);
    end
    reg_rd(A_STAT, d);
    chk({tag, " fail status"}, d, 32'd1);
    reg_wr(A_IRQ, 32'd2);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus idle", bus_word(lframe_n, lad_oe, lad_out), bus_word(1'b1, 1'b0, 4'h0));
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    reg_rd(A_STAT, d);
    chk("R1 R10 status idle phase 0", d, 32'd1);

    // directed
    dat[0] = 8'hA5;
    run_io(1'b1, 1'b1, 1, 16'h03F8, 0, -1, 4);
    run_io(1'b0, 1'b0, 4, 16'h00FE, 1, -1, 4);
    run_io(1'b0, 1'b1, 3, 16'h1234, 2, -1, 4);
    run_io(1'b0, 1'b0, 2, 16'hFFFF, 3, -1, 3);
    run_io(1'b0, 1'b0, 3, 16'h0060, 0, 1, 4);
    dat[0] = 8'h3C;
    run_io(1'b1, 1'b0, 1, 16'h0080, 1, 0, 4);
    run_io(1'b0, 1'b0, 2, 16'h0200, 3, -1, 2);
    dat[0] = 8'h77;
    run_io(1'b1, 1'b0, 1, 16'h0201, 1, -1, 0);
    refused(4'b0010, 1, "R2 memory type");
    refused(4'b0101, 1, "R2 fwh type");
    refused(4'b0000, 0, "R13 zero length");

    // random
    for (int t = 0; t < 24; t++) begin
      bit rw = 1'($urandom);
      int ln = 1 + int'($urandom % 4);
      for (int i = 0; i < 4; i++) dat[i] = 8'($urandom);
      run_io(rw, 1'($urandom), ln, 16'($urandom), int'($urandom % 3), -1, 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule